// File: doc/BRIEF.md
# Serial One-Time Register Programmer with Sector Lockdown

This block is the command side of a serial memory device's user security area. An SPI host (mode 0, MSB first, active-low chip select) reaches two behavioural stores through it. The first is a 64-byte user region, whose bits can only be cleared by programming. The second is a lockdown register with one sticky bit for each sector. The block oversamples the SPI pins with its own clock, assembles bytes, and decodes commands in a single state machine.

A program command is a fixed four-byte opcode sequence followed by data bytes. The data bytes collect into a staging buffer, and the write pointer wraps modulo the region size. The self-timed cycle starts only when chip select is released. A lockdown command takes a 24-bit address, and the address picks the sector. Two read commands return the user region and the lockdown register after three dummy bytes. A status command can be used while a cycle is running. The write-protect input blocks both program and lockdown.

States: `ST_IDLE` waits for the opcode byte. `ST_SEQ` matches opcode bytes 2 to 4 of the program sequence. `ST_PDATA` collects data bytes. `ST_LADDR` collects the three lockdown address bytes. `ST_LARM` is armed for a lockdown. `ST_DUMMY` skips three dummy bytes. `ST_RUSR`, `ST_RLCK` and `ST_STAT` shift data out. `ST_IGNORE` discards the rest of a frame.

Transitions:
- `ST_IDLE` goes to `ST_SEQ`, `ST_LADDR`, `ST_DUMMY` or `ST_STAT` according to the opcode, or to `ST_IGNORE` when busy or when the opcode is unknown.
- `ST_SEQ` goes to `ST_PDATA` on a full match, or to `ST_IGNORE` on a mismatch.
- `ST_LADDR` goes to `ST_LARM` after the third address byte.
- `ST_DUMMY` goes to `ST_RUSR` or `ST_RLCK` after the third dummy byte.
- Every state returns to `ST_IDLE` when chip select is high.

Top module: `secprog_ctrl`

## Requirements
- R1: After reset, `busy` and `spi_miso_oe` are 0, every user byte reads 0xFF, and every lockdown byte reads 0x00.
- R2: A program command is accepted only if its first four bytes are exactly 0xC3, 0x5A, 0x1E, 0x87 in that order. A wrong byte, or a frame that ends before the fourth byte, leaves `busy` low and the user region unchanged.
- R3: Data bytes after the sequence stage at offsets 0, 1, 2 and so on, wrapping modulo 64, so byte 65 replaces offset 0. On completion, each user byte becomes its old value AND its staged value, and offsets that were not written keep their value.
- R4: `busy` stays low while data is clocked in. It rises only after chip select goes high, and it stays high for exactly `PROG_CYCLES` clock cycles.
- R5: Opcode 0x77 followed by three dummy bytes returns user bytes starting at offset 0 and wrapping after 63 back to 0.
- R6: Opcode 0x3D followed by three address bytes (24 bits, MSB first) locks sector `addr[18:16]` when chip select rises, and the lock persists. A frame with fewer than three address bytes is ignored.
- R7: Opcode 0x35 followed by three dummy bytes returns one byte per sector, starting at sector 0 and wrapping after sector 7: 0xFF if the sector is locked, 0x00 if not.
- R8: If `wp` is high when chip select rises, a program or lockdown command starts no cycle and changes nothing.
- R9: While `busy` is high, every opcode except 0xD7 is ignored. Opcode 0xD7 returns the status byte repeatedly, with bit 0 = busy, bit 1 = wp, and all other bits 0.
- R10: `spi_miso_oe` rises once the output phase of a read begins and falls on the clock after chip select rises.
- R11: MOSI is sampled on SCK rising edges, and MISO changes after SCK falling edges, MSB first.
- R12: An unknown opcode is ignored: no output enable, no cycle, no change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples SPI |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for MISO (low means tri-stated) |
| wp | input | 1 | Write protect, active high |
| busy | output | 1 | Self-timed cycle in progress |

## Verification
The assertions assume several things about the inputs. `wp` is synchronous to `clk`. SCK edges are separated by enough clock cycles for the two-stage synchronizer to see each level. SCK is low whenever chip select changes. The bench drives every pin on the falling edge of `clk`. It holds each SCK level for six clock cycles, holds `wp` steady for the whole of each frame, and keeps SCK low for six cycles around each chip-select edge. A new cycle is therefore never requested while one is already running, which is the condition the timer's assertions rely on.

// File: rtl/secprog_pkg.sv
package secprog_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEQ,
        ST_PDATA,
        ST_LADDR,
        ST_LARM,
        ST_DUMMY,
        ST_RUSR,
        ST_RLCK,
        ST_STAT,
        ST_IGNORE
    } sp_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_LOCK
    } sp_pend_e;

    localparam logic [7:0] OPC_RD_USR = 8'h77;
    localparam logic [7:0] OPC_RD_LCK = 8'h35;
    localparam logic [7:0] OPC_LOCK   = 8'h3D;
    localparam logic [7:0] OPC_STATUS = 8'hD7;

    function automatic logic [7:0] prog_seq_byte(input logic [1:0] idx);
        unique case (idx)
            2'd0: prog_seq_byte = 8'hC3;
            2'd1: prog_seq_byte = 8'h5A;
            2'd2: prog_seq_byte = 8'h1E;
            2'd3: prog_seq_byte = 8'h87;
        endcase
    endfunction

endpackage

// File: rtl/secprog_sync.sv
module secprog_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic csn,
    input  logic sck,
    input  logic mosi,
    output logic cs_act,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s
);
    logic [2:0] cs_sh;
    logic [2:0] sck_sh;
    logic [1:0] mo_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_sh  <= 3'b111;
            sck_sh <= 3'b000;
            mo_sh  <= 2'b00;
        end else begin
            cs_sh  <= {cs_sh[1:0], csn};
            sck_sh <= {sck_sh[1:0], sck};
            mo_sh  <= {mo_sh[0], mosi};
        end
    end

    assign cs_act   = ~cs_sh[1];
    assign cs_rise  = cs_sh[1] & ~cs_sh[2];
    assign sck_rise = sck_sh[1] & ~sck_sh[2];
    assign sck_fall = ~sck_sh[1] & sck_sh[2];
    assign mosi_s   = mo_sh[1];

endmodule

// File: rtl/secprog_timer.sv
module secprog_timer #(
    parameter int CYCLES = 64,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    logic [CW-1:0] cnt_q;
    logic          busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(CYCLES - 1);
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == '0);

    p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    p_done_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/secprog_store.sv
module secprog_store
    import secprog_pkg::*;
#(
    parameter int BYTES = 64,
    parameter int NSECT = 8,
    localparam int IDX_W  = $clog2(BYTES),
    localparam int SECT_W = $clog2(NSECT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stage_clr,
    input  logic              stage_we,
    input  logic [IDX_W-1:0]  stage_idx,
    input  logic [7:0]        stage_wdata,
    input  logic              prog_go,
    input  logic              lock_go,
    input  logic [SECT_W-1:0] lock_sect,
    input  logic              commit,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [7:0]        rd_data,
    output logic [NSECT-1:0]  lock_bits
);
    logic [7:0]        user_q  [BYTES];
    logic [7:0]        stage_q [BYTES];
    logic [NSECT-1:0]  lock_q;
    logic [SECT_W-1:0] sect_q;
    sp_pend_e          pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) begin
                user_q[i]  <= 8'hFF;
                stage_q[i] <= 8'hFF;
            end
            lock_q <= '0;
            sect_q <= '0;
            pend_q <= OP_NONE;
        end else begin
            if (stage_clr) begin
                for (int i = 0; i < BYTES; i++) stage_q[i] <= 8'hFF;
            end else if (stage_we) begin
                stage_q[stage_idx] <= stage_wdata;
            end
            if (prog_go) begin
                pend_q <= OP_PROG;
            end else if (lock_go) begin
                pend_q <= OP_LOCK;
                sect_q <= lock_sect;
            end else if (commit) begin
                unique case (pend_q)
                    OP_PROG: for (int i = 0; i < BYTES; i++)
                                 user_q[i] <= user_q[i] & stage_q[i];
                    OP_LOCK: lock_q[sect_q] <= 1'b1;
                    default: ;
                endcase
                pend_q <= OP_NONE;
            end
        end
    end

    assign rd_data   = user_q[rd_idx];
    assign lock_bits = lock_q;

    p_commit_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> pend_q != OP_NONE);

    for (genvar s = 0; s < NSECT; s++) begin : g_lock_chk
        p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            lock_q[s] |=> lock_q[s]);
    end

    for (genvar b = 0; b < BYTES; b++) begin : g_user_chk
        p_user_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !commit |=> $stable(user_q[b]));
    end

endmodule

// File: rtl/secprog_ctrl.sv
module secprog_ctrl
    import secprog_pkg::*;
#(
    parameter int BYTES       = 64,
    parameter int NSECT       = 8,
    parameter int SECT_LSB    = 16,
    parameter int PROG_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_csn,
    input  logic spi_sck,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe,
    input  logic wp,
    output logic busy
);
    localparam int IDX_W  = $clog2(BYTES);
    localparam int SECT_W = $clog2(NSECT);
    localparam int ADDR_W = 24;

    logic cs_act, cs_rise, sck_rise, sck_fall, mosi_s;
    logic done, t_start;

    sp_state_e         state_q, state_d;
    logic [1:0]        cnt_q, cnt_d;
    logic [IDX_W-1:0]  ptr_q, ptr_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              rdlck_q, rdlck_d;
    logic [6:0]        rx_q;
    logic [2:0]        bitc_q;
    logic [7:0]        tx_q;
    logic              miso_q, oe_q;
    logic [IDX_W-1:0]  rdp_q;

    logic              byte_done;
    logic [7:0]        rx_byte;
    logic              stage_clr, stage_we, prog_go, lock_go;
    logic [7:0]        usr_rd;
    logic [NSECT-1:0]  lock_bits;
    logic [7:0]        next_out;
    logic              out_st;

    secprog_sync u_sync (
        .clk(clk), .rst_n(rst_n), .csn(spi_csn), .sck(spi_sck), .mosi(spi_mosi),
        .cs_act(cs_act), .cs_rise(cs_rise), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .mosi_s(mosi_s)
    );

    secprog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(t_start), .busy(busy), .done(done)
    );

    secprog_store #(.BYTES(BYTES), .NSECT(NSECT)) u_store (
        .clk(clk), .rst_n(rst_n),
        .stage_clr(stage_clr), .stage_we(stage_we), .stage_idx(ptr_q),
        .stage_wdata(rx_byte), .prog_go(prog_go), .lock_go(lock_go),
        .lock_sect(addr_q[SECT_LSB +: SECT_W]), .commit(done),
        .rd_idx(rdp_q), .rd_data(usr_rd), .lock_bits(lock_bits)
    );

    assign byte_done = cs_act && sck_rise && (bitc_q == 3'd7);
    assign rx_byte   = {rx_q, mosi_s};
    assign prog_go   = cs_rise && (state_q == ST_PDATA) && !wp && !busy;
    assign lock_go   = cs_rise && (state_q == ST_LARM) && !wp && !busy;
    assign t_start   = prog_go || lock_go;

    // state register and byte assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ptr_q   <= '0;
            addr_q  <= '0;
            rdlck_q <= 1'b0;
            rx_q    <= '0;
            bitc_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ptr_q   <= ptr_d;
            addr_q  <= addr_d;
            rdlck_q <= rdlck_d;
            if (!cs_act) begin
                bitc_q <= '0;
            end else if (sck_rise) begin
                rx_q   <= {rx_q[5:0], mosi_s};
                bitc_q <= bitc_q + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        ptr_d     = ptr_q;
        addr_d    = addr_q;
        rdlck_d   = rdlck_q;
        stage_clr = 1'b0;
        stage_we  = 1'b0;
        if (!cs_act) begin
            state_d = ST_IDLE;
        end else if (byte_done) begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_d = '0;
                    if (busy) begin
                        state_d = (rx_byte == OPC_STATUS) ? ST_STAT : ST_IGNORE;
                    end else if (rx_byte == prog_seq_byte(2'd0)) begin
                        state_d = ST_SEQ;
                        cnt_d   = 2'd1;
                    end else if (rx_byte == OPC_LOCK) begin
                        state_d = ST_LADDR;
                    end else if (rx_byte == OPC_RD_USR || rx_byte == OPC_RD_LCK) begin
                        state_d = ST_DUMMY;
                        rdlck_d = (rx_byte == OPC_RD_LCK);
                    end else if (rx_byte == OPC_STATUS) begin
                        state_d = ST_STAT;
                    end else begin
                        state_d = ST_IGNORE;
                    end
                end
                ST_SEQ: begin
                    if (rx_byte != prog_seq_byte(cnt_q)) begin
                        state_d = ST_IGNORE;
                    end else if (cnt_q == 2'd3) begin
                        state_d   = ST_PDATA;
                        ptr_d     = '0;
                        stage_clr = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_PDATA: begin
                    stage_we = 1'b1;
                    ptr_d    = ptr_q + 1'b1;
                end
                ST_LADDR: begin
                    addr_d = {addr_q[ADDR_W-9:0], rx_byte};
                    if (cnt_q == 2'd2) state_d = ST_LARM;
                    else               cnt_d   = cnt_q + 1'b1;
                end
                ST_DUMMY: begin
                    if (cnt_q == 2'd2) state_d = rdlck_q ? ST_RLCK : ST_RUSR;
                    else               cnt_d   = cnt_q + 1'b1;
                end
                ST_LARM, ST_RUSR, ST_RLCK, ST_STAT, ST_IGNORE: ;
            endcase
        end
    end

    assign out_st = (state_q == ST_RUSR) || (state_q == ST_RLCK) || (state_q == ST_STAT);

    always_comb begin
        unique case (state_q)
            ST_RUSR: next_out = usr_rd;
            ST_RLCK: next_out = lock_bits[rdp_q[SECT_W-1:0]] ? 8'hFF : 8'h00;
            default: next_out = {6'b0, wp, busy};
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miso_q <= 1'b0;
            oe_q   <= 1'b0;
            tx_q   <= '0;
            rdp_q  <= '0;
        end else if (!cs_act) begin
            oe_q <= 1'b0;
        end else begin
            if (byte_done && (state_d == ST_RUSR || state_d == ST_RLCK
                              || state_d == ST_STAT) && !out_st) begin
                oe_q  <= 1'b1;
                rdp_q <= '0;
            end
            if (sck_fall && out_st && oe_q) begin
                if (bitc_q == 3'd0) begin
                    miso_q <= next_out[7];
                    tx_q   <= {next_out[6:0], 1'b0};
                    rdp_q  <= rdp_q + 1'b1;
                end else begin
                    miso_q <= tx_q[7];
                    tx_q   <= {tx_q[6:0], 1'b0};
                end
            end
        end
    end

    assign spi_miso    = miso_q;
    assign spi_miso_oe = oe_q;

    p_oe_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !spi_miso_oe);
    p_wp_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && wp && !busy) |=> !busy);
    p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (state_q == ST_IDLE || state_q == ST_STAT || state_q == ST_IGNORE));
    p_oe_only_out_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> !spi_miso_oe);

endmodule

// File: tb/secprog_ctrl_test.sv
module secprog_ctrl_test;
    localparam int CLK_PER = 10;
    localparam int PCYC    = 600;
    localparam int HB      = 6;

    typedef logic [7:0] bq_t[$];

    logic clk = 1'b0, rst_n = 1'b0;
    logic csn = 1'b1, sck = 1'b0, mosi = 1'b0, wp = 1'b0;
    logic miso, miso_oe, busy;

    int n_chk = 0, n_fail = 0;
    int pulses = 0, cur_len = 0, last_len = 0;
    logic [7:0] umodel [64];
    logic [7:0] lmodel;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] got;
    event       got_ev;

    always #(CLK_PER/2) clk = ~clk;

    secprog_ctrl #(.PROG_CYCLES(PCYC)) uut (
        .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sck(sck),
        .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe),
        .wp(wp), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // busy pulse monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) cur_len++;
            else if (cur_len != 0) begin
                last_len = cur_len;
                pulses++;
                cur_len = 0;
            end
        end
    end

    // scoreboard monitor
    always @(got_ev) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(got === e, t, got, e);
    end

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            mosi = tx[b];
            repeat (HB) @(negedge clk);
            rx[b] = miso;
            sck = 1'b1;
            repeat (HB) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic cs_begin();
        @(negedge clk);
        csn = 1'b0;
        repeat (HB) @(negedge clk);
    endtask

    task automatic cs_end();
        repeat (HB) @(negedge clk);
        csn = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic send(input bq_t q);
        logic [7:0] r;
        foreach (q[i]) xfer(q[i], r);
    endtask

    task automatic rd_exp(input logic [7:0] e, input string t);
        logic [7:0] r;
        exp_q.push_back(e);
        tag_q.push_back(t);
        xfer(8'h00, r);
        got = r;
        ->got_ev;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        repeat (10) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic read_user(input int n, input string t);
        cs_begin();
        send('{8'h77, 8'h00, 8'h00, 8'h00});
        check(miso_oe === 1'b1, "R10 oe in read", miso_oe, 1);
        for (int i = 0; i < n; i++) rd_exp(umodel[i % 64], t);
        cs_end();
        check(miso_oe === 1'b0, "R10 oe after cs", miso_oe, 0);
    endtask

    task automatic read_lock(input int n, input string t);
        cs_begin();
        send('{8'h35, 8'h00, 8'h00, 8'h00});
        for (int i = 0; i < n; i++) rd_exp(lmodel[i % 8] ? 8'hFF : 8'h00, t);
        cs_end();
    endtask

    task automatic status(input logic [7:0] e, input string t);
        cs_begin();
        send('{8'hD7});
        rd_exp(e, t);
        rd_exp(e, t);
        cs_end();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int p0;
        bq_t d;
        for (int i = 0; i < 64; i++) umodel[i] = 8'hFF;
        lmodel = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        check(busy === 1'b0, "R1 busy", busy, 0);
        check(miso_oe === 1'b0, "R1 oe", miso_oe, 0);
        status(8'h00, "R9 idle status");
        read_user(3, "R1 R5 R11 user reset");
        read_lock(8, "R1 R7 lock reset");

        // R3 R4 program with wrap
        d = '{8'hC3, 8'h5A, 8'h1E, 8'h87};
        for (int i = 0; i < 66; i++)
            d.push_back(i == 64 ? 8'h0F : (i == 65 ? 8'h3C : 8'(i) ^ 8'hA0));
        cs_begin();
        send(d);
        repeat (20) @(negedge clk);
        check(busy === 1'b0, "R4 no busy before cs rise", busy, 0);
        cs_end();
        check(busy === 1'b1, "R4 busy after cs rise", busy, 1);
        status(8'h01, "R9 busy status");
        // program attempt while busy: ignored
        cs_begin();
        send('{8'hC3, 8'h5A, 8'h1E, 8'h87, 8'h00, 8'h00});
        cs_end();
        wait_idle();
        check(pulses == 1, "R9 busy ignores program", pulses, 1);
        check(last_len == PCYC, "R4 busy length", last_len, PCYC);
        for (int i = 0; i < 64; i++) umodel[i] = 8'(i) ^ 8'hA0;
        umodel[0] = 8'h0F;
        umodel[1] = 8'h3C;
        read_user(65, "R3 R5 wrap data");

        // R2 wrong byte and short sequence
        p0 = pulses;
        cs_begin();
        send('{8'hC3, 8'h5A, 8'h1F, 8'h87, 8'h00, 8'h00});
        cs_end();
        repeat (20) @(negedge clk);
        check(pulses == p0 && busy === 1'b0, "R2 bad sequence", pulses, p0);
        cs_begin();
        send('{8'hC3, 8'h5A, 8'h1E});
        cs_end();
        repeat (20) @(negedge clk);
        check(pulses == p0 && busy === 1'b0, "R2 short sequence", pulses, p0);
        read_user(4, "R2 unchanged");

        // R8 write protect
        wp = 1'b1;
        cs_begin();
        send('{8'hC3, 8'h5A, 8'h1E, 8'h87, 8'h00, 8'h00, 8'h00});
        cs_end();
        repeat (20) @(negedge clk);
        check(pulses == p0 && busy === 1'b0, "R8 wp program", pulses, p0);
        cs_begin();
        send('{8'h3D, 8'h07, 8'h00, 8'h00});
        cs_end();
        repeat (20) @(negedge clk);
        check(pulses == p0 && busy === 1'b0, "R8 wp lock", pulses, p0);
        status(8'h02, "R9 wp status");
        wp = 1'b0;
        repeat (4) @(negedge clk);
        read_user(3, "R8 user unchanged");
        read_lock(8, "R8 lock unchanged");

        // R3 bits only clear
        cs_begin();
        send('{8'hC3, 8'h5A, 8'h1E, 8'h87, 8'hF0});
        cs_end();
        wait_idle();
        check(pulses == p0 + 1, "R3 second program ran", pulses, p0 + 1);
        umodel[0] = 8'h00;
        read_user(3, "R3 and-merge");

        // R6 R7 lockdown
        p0 = pulses;
        cs_begin();
        send('{8'h3D, 8'h05, 8'h12, 8'h34});
        cs_end();
        wait_idle();
        check(pulses == p0 + 1 && last_len == PCYC, "R6 lock cycle", last_len, PCYC);
        lmodel[5] = 1'b1;
        read_lock(9, "R6 R7 sector5");
        p0 = pulses;
        cs_begin();
        send('{8'h3D, 8'h02, 8'hFF});
        cs_end();
        repeat (20) @(negedge clk);
        check(pulses == p0 && busy === 1'b0, "R6 short address", pulses, p0);
        cs_begin();
        send('{8'h3D, 8'h02, 8'hFF, 8'hFF});
        cs_end();
        wait_idle();
        lmodel[2] = 1'b1;
        read_lock(10, "R6 R7 sector2 sticky");

        // R12 unknown opcode
        p0 = pulses;
        cs_begin();
        send('{8'h11, 8'h00, 8'h00, 8'h00, 8'h00});
        check(miso_oe === 1'b0, "R12 no oe", miso_oe, 0);
        cs_end();
        repeat (20) @(negedge clk);
        check(pulses == p0 && busy === 1'b0, "R12 no cycle", pulses, p0);
        read_user(2, "R12 user unchanged");

        repeat (10) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule